// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM Generator

This block drives two pulse-width-modulated outputs. Each channel takes one of several incoming clock-enable pulse streams and divides it with a small prescaler. Two counts are then played in turn: the output is high for a number of prescaled ticks, then low for another number of ticks, and the pattern repeats. The period is therefore the sum of the two counts. There is no period register and no compare register. Software converts a wanted period and duty into these counts and handles any polarity inversion itself.

Every setting sits in a small register file behind a synchronous write port with a combinational read. One shared control word holds the clock select, the prescaler divide, a clock gate and an output enable for each channel. Each channel also has its own 32-bit duty word holding both counts. A channel runs only while both of its enables are set. Clearing the output enable forces the output low in the next cycle. Re-enabling always starts a fresh high phase. New counts written to a running channel are picked up at the next high/low phase boundary, so the phase already in progress is never cut short.

Top module: `hl_pwm_dual`

## Requirements
- R1: With divide field N, a channel's phase counter advances once every N+1 pulses of its selected source. With a source that pulses every cycle, one count lasts N+1 clock cycles.
- R2: In a duty word, bits 31:16 are the high count and bits 15:0 are the low count. The word for channel 0 is at address 1 and the word for channel 1 is at address 2.
- R3: With both counts non-zero, the output is high for high×(N+1) cycles starting from the edge that enables the channel. It is then low for low×(N+1) cycles, and the pattern repeats.
- R4: A low count of zero gives a constant high output, as long as the high count is non-zero.
- R5: A high count of zero gives a constant low output.
- R6: The output stays low unless both the clock-enable bit and the output-enable bit of that channel are set.
- R7: Clearing the output-enable bit drives the output low from the next clock edge, even in the middle of a high phase.
- R8: Enabling a channel again restarts it with a full high phase and a cleared prescaler.
- R9: Counts written while a channel runs take effect only at the next phase boundary. The phase in progress finishes with its old length.
- R10: The 2-bit clock select picks src_tick[sel]. While the selected source never pulses, the output holds its current level.
- R11: Address 0 reads back the control word. Addresses 1 and 2 read back the duty words. Address 3 reads 0.
- R12: Control word layout: channel c uses bits starting at 16c. Divide is in [6:0], select in [8:7], clock enable at bit 9 and output enable at bit 10 (relative to 16c).
- R13: After reset, both outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Clock-source enable pulses, one per selectable source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 and 2 duty words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pwm_o | output | 2 | PWM outputs, channel 0 in bit 0 |

## Verification
Two events can land in the same cycle: a duty-word write to a running channel, and that channel's own phase boundary. Whichever edge the write lands on, the new counts must not shorten the phase in progress. The bench provokes this by rewriting a channel's counts one cycle after enabling it, while its high phase is still running. It then compares each later cycle of the output against a waveform that switches to the new counts only at the first boundary. Turning a channel off in mid-phase is a second collision, between the stop and the counter's own progress. It is judged by requiring a low output in the very next cycle and a full-length high phase after re-enable.

// File: rtl/hl_pwm_pkg.sv
// Package: shared widths and the per-channel control field layout of the
// dual high/low PWM. The packed struct order matches the bit positions
// that software uses inside each 16-bit channel slice of the control word.
package hl_pwm_pkg;
    parameter int DIV_W   = 7;            // prescaler divide field width
    parameter int SEL_W   = 2;            // clock-source select width
    parameter int CNT_W   = 16;           // high and low count width
    parameter int NUM_SRC = 1 << SEL_W;   // number of selectable sources
    parameter int SLICE_W = 16;           // control bits reserved per channel
    parameter int WORD_W  = 32;           // register word width

    // Decoded channel control: oe is the MSB, div sits in the LSBs.
    typedef struct packed {
        logic             oe;
        logic             ce;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } ch_ctrl_t;

    localparam int CTRL_USED_W = $bits(ch_ctrl_t);
endpackage

// File: rtl/hl_pwm_tick_div.sv
// Module: source mux and prescaler for one channel.
// Selects one of the source pulse streams and emits a single-cycle advance
// strobe on every (div+1)-th selected pulse. Assumes run is a registered
// enable; while run is low the prescaler is held at zero so that a restart
// always begins with a full division interval.
module hl_pwm_tick_div
    import hl_pwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DIV_W-1:0]   div,
    output logic               adv
);
    logic             sel_tick;
    logic [DIV_W-1:0] div_cnt;
    logic             wrap;

    // Pick the selected source pulse.
    assign sel_tick = src_tick[sel];
    // Wrap test uses >= so a divide value lowered at run time cannot overrun.
    assign wrap     = (div_cnt >= div);
    assign adv      = run & sel_tick & wrap;

    // Count selected pulses; clear on wrap or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!run) begin
            div_cnt <= '0;
        end else if (sel_tick) begin
            if (wrap) div_cnt <= '0;
            else      div_cnt <= div_cnt + 1'b1;
        end
    end

    // R1: an advance always restarts the division interval.
    assert_adv_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (div_cnt == '0));

    // R10: without a selected pulse the prescaler does not move.
    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sel_tick) |=> $stable(div_cnt));
endmodule

// File: rtl/hl_pwm_phase_ctr.sv
// Module: high/low phase sequencer for one channel.
// Plays a high phase of hi_cur advances and a low phase of lo_cur advances
// in turn. New counts are sampled only at a phase boundary. A zero low count
// keeps the channel in its high phase; a zero high count keeps the output low.
// Assumes adv is a single-cycle strobe qualified by run.
module hl_pwm_phase_ctr
    import hl_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adv,
    input  logic [CNT_W-1:0] hi_in,
    input  logic [CNT_W-1:0] lo_in,
    output logic             pwm
);
    logic             phase_hi;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_cur;
    logic [CNT_W-1:0] lo_cur;
    logic [CNT_W-1:0] len;
    logic             at_end;
    logic             next_hi;

    // Length of the phase in progress and the boundary test.
    assign len    = phase_hi ? hi_cur : lo_cur;
    assign at_end = (len == '0) || (cnt == len - 1'b1);

    // Phase after a boundary, chosen from the counts loaded there.
    always_comb begin
        if (lo_in == '0)      next_hi = 1'b1;
        else if (hi_in == '0) next_hi = 1'b0;
        else                  next_hi = ~phase_hi;
    end

    // Sequencer state: reset/stop loads a fresh high phase, boundaries reload counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_hi <= 1'b1;
            cnt      <= '0;
            hi_cur   <= '0;
            lo_cur   <= '0;
        end else if (!run) begin
            phase_hi <= 1'b1;
            cnt      <= '0;
            hi_cur   <= hi_in;
            lo_cur   <= lo_in;
        end else if (adv) begin
            if (at_end) begin
                cnt      <= '0;
                hi_cur   <= hi_in;
                lo_cur   <= lo_in;
                phase_hi <= next_hi;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Output: high only during a non-empty high phase of a running channel.
    assign pwm = run & phase_hi & (hi_cur != '0);

    // R8: a stopped channel is parked at the start of a high phase.
    assert_fresh_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_hi && cnt == '0));

    // R9: between advances the counts and the position do not change.
    assert_counts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !adv) |=> ($stable(hi_cur) && $stable(lo_cur) && $stable(cnt)));

    // R3: the position never passes the end of the phase in progress.
    assert_cnt_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((len == '0) ? (cnt == '0) : (cnt < len)));
endmodule

// File: rtl/hl_pwm_dual.sv
// Module: two-channel high/low count PWM with a small register file.
// Holds one shared control word and one duty word per channel, decodes each
// channel's control slice, and instantiates a prescaler and a sequencer per
// channel. Writes are synchronous; reads are combinational from reg_addr.
// Assumes NUM_CH * SLICE_W fits in one register word.
module hl_pwm_dual
    import hl_pwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0]  pwm_o
);
    localparam int HI_LSB = WORD_W - CNT_W;

    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] duty_q [NUM_CH];

    // Register writes: address 0 is control, 1..NUM_CH are duty words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            for (int i = 0; i < NUM_CH; i++) duty_q[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == '0) ctrl_q <= reg_wdata;
            for (int i = 0; i < NUM_CH; i++)
                if (int'(reg_addr) == i + 1) duty_q[i] <= reg_wdata;
        end
    end

    // Register reads: unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) reg_rdata = ctrl_q;
        for (int i = 0; i < NUM_CH; i++)
            if (int'(reg_addr) == i + 1) reg_rdata = duty_q[i];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_ctrl_t cfg;
        logic     run;
        logic     adv;

        // Decode this channel's control slice and its run condition.
        assign cfg = ch_ctrl_t'(ctrl_q[c*SLICE_W +: CTRL_USED_W]);
        assign run = cfg.ce & cfg.oe;

        hl_pwm_tick_div u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .src_tick (src_tick),
            .sel      (cfg.sel),
            .div      (cfg.div),
            .adv      (adv)
        );

        hl_pwm_phase_ctr u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .adv   (adv),
            .hi_in (duty_q[c][HI_LSB +: CNT_W]),
            .lo_in (duty_q[c][0 +: CNT_W]),
            .pwm   (pwm_o[c])
        );

        // R6: a channel missing either enable drives low.
        assert_gated_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg.ce && cfg.oe) |-> !pwm_o[c]);

        // R7: the cycle after an output-enable write to zero is low.
        assert_stop_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cfg.oe) |-> !pwm_o[c]);
    end
endmodule

// File: tb/hl_pwm_dual_tb.sv
// Bench: sweeps counts and divide values on both channels and compares every
// cycle of the outputs with a waveform computed from the requirements.
module hl_pwm_dual_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  pwm_o;
    logic        src1 = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    // Sources: 0 every cycle, 1 every other cycle, 2 never, 3 every cycle.
    always @(negedge clk) src1 <= ~src1;
    assign src_tick = {1'b1, 1'b0, src1, 1'b1};

    hl_pwm_dual u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o)
    );

    // R12: build one channel's control slice.
    function automatic logic [15:0] slice(int div, int sel, bit ce, bit oe);
        return 16'((oe << 10) | (ce << 9) | (sel << 7) | div);
    endfunction

    // R3/R4/R5: expected level j cycles after the enabling edge.
    function automatic logic exp_lvl(int j, int hi, int lo, int d);
        int per;
        if (hi == 0) return 1'b0;
        if (lo == 0) return 1'b1;
        per = (hi + lo) * (d + 1);
        return ((j % per) < hi * (d + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Run one configuration on both channels (ch1 uses source 3) and compare.
    task automatic run_cfg(int hi, int lo, int d, int n);
        logic [1:0] bad_act, bad_exp;
        bit bad;
        bad = 0; bad_act = '0; bad_exp = '0;
        wr(2'd1, {16'(hi), 16'(lo)});
        wr(2'd2, {16'(hi), 16'(lo)});
        wr(2'd0, {slice(d, 3, 1, 1), slice(d, 0, 1, 1)});
        for (int j = 0; j < n; j++) begin
            for (int c = 0; c < 2; c++) begin
                if (!bad && pwm_o[c] !== exp_lvl(j, hi, lo, d)) begin
                    bad = 1; bad_act = pwm_o; bad_exp = {2{exp_lvl(j, hi, lo, d)}};
                end
            end
            @(negedge clk);
        end
        if (hi == 0)      check("R5 const low", {30'd0, bad_act}, {30'd0, bad_exp});
        else if (lo == 0) check("R4 const high", {30'd0, bad_act}, {30'd0, bad_exp});
        else              check("R3/R1 waveform", {30'd0, bad_act}, {30'd0, bad_exp});
        wr(2'd0, 32'd0);
    endtask

    initial begin
        int exp_seq [14];
        bit ok;
        reg_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state.
        check("R13 outputs", {30'd0, pwm_o}, 32'd0);
        rd_check("R13 ctrl", 2'd0, 32'd0);
        rd_check("R13 duty0", 2'd1, 32'd0);
        rd_check("R13 duty1", 2'd2, 32'd0);

        // R11/R12/R2: readback.
        wr(2'd1, 32'h0003_0005);
        wr(2'd2, 32'h0007_0001);
        wr(2'd0, 32'h0000_0380);
        rd_check("R11 ctrl", 2'd0, 32'h0000_0380);
        rd_check("R2 duty0", 2'd1, 32'h0003_0005);
        rd_check("R2 duty1", 2'd2, 32'h0007_0001);
        rd_check("R11 unmapped", 2'd3, 32'd0);
        check("R6 clk-en only low", {31'd0, pwm_o[0]}, 32'd0);
        wr(2'd0, {16'd0, slice(0, 0, 0, 1)});
        repeat (6) @(negedge clk);
        check("R6 out-en only low", {31'd0, pwm_o[0]}, 32'd0);
        wr(2'd0, 32'd0);

        // R1/R3/R4/R5/R2: sweep counts and divide.
        for (int d = 0; d < 3; d++)
            for (int hi = 0; hi < 4; hi++)
                for (int lo = 0; lo < 4; lo++)
                    run_cfg(hi, lo, d, 2 * (hi + lo) * (d + 1) + 4);
        run_cfg(1, 1, 127, 520);  // R1 widest divide

        // R9: rewrite counts during the first high phase.
        wr(2'd1, 32'h0003_0003);
        wr(2'd0, {16'd0, slice(0, 0, 1, 1)});
        ok = (pwm_o[0] === 1'b1);
        wr(2'd1, 32'h0001_0005);
        for (int j = 0; j < 14; j++) exp_seq[j] = (j < 3 || j == 8) ? 1 : 0;
        for (int j = 1; j < 14; j++) begin
            if (pwm_o[0] !== 1'(exp_seq[j])) ok = 0;
            @(negedge clk);
        end
        check("R9 update at boundary", {31'd0, ok}, 32'd1);
        wr(2'd0, 32'd0);

        // R7/R8: stop mid-high, then restart.
        wr(2'd1, 32'h0005_0005);
        wr(2'd0, {16'd0, slice(0, 0, 1, 1)});
        @(negedge clk);
        check("R7 high before stop", {31'd0, pwm_o[0]}, 32'd1);
        wr(2'd0, {16'd0, slice(0, 0, 1, 0)});
        check("R7 low after stop", {31'd0, pwm_o[0]}, 32'd0);
        wr(2'd0, {16'd0, slice(0, 0, 1, 1)});
        ok = 1;
        for (int j = 0; j < 12; j++) begin
            if (pwm_o[0] !== exp_lvl(j, 5, 5, 0)) ok = 0;
            @(negedge clk);
        end
        check("R8 fresh high phase", {31'd0, ok}, 32'd1);
        wr(2'd0, 32'd0);

        // R10: a silent source freezes the output.
        wr(2'd1, 32'h0002_0002);
        wr(2'd0, {16'd0, slice(0, 2, 1, 1)});
        ok = 1;
        for (int j = 0; j < 20; j++) begin
            if (pwm_o[0] !== 1'b1) ok = 0;
            @(negedge clk);
        end
        check("R10 silent source holds", {31'd0, ok}, 32'd1);
        wr(2'd0, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule